// File: doc/BRIEF.md
# Double-Buffered List Select Status Controller

This block keeps the status byte of a conversion sequencer that works from two command lists and two result lists. It records which command list and which result list are in use. In double-buffer operation each selection flips on its own sequencer events. In single-buffer operation each selection is held at zero. It also holds a sticky fatal flag for an uncorrectable (double-bit) ECC error that stops the sequencer, and it reports whether the sequencer is idle and can take a restart at once.

Software reads the byte through a plain read/write port. It may steer the two list selects only while the converter is disabled or special-mode access is granted. The sequencer drives the events: load-OK, restart, busy, first result stored, abort, ECC error and idle. It reads back the two selects and a halt line that stops further sequencing while the fatal flag is set.

Top module: `lsel_status_ctrl`

## Requirements
- R1: `reg_rdata` carries the command-list select at bit 7, the result-list select at bit 6, the fatal ECC flag at bit 5 and the ready flag at bit 3. Bits 4, 2, 1 and 0 always read 0.
- R2: While `rst_n` is low the selects and the fatal flag are 0. With `seq_idle` high, `reg_rdata` reads 0x08.
- R3: A write (`reg_wr`=1) loads `reg_wdata[7]` into the command select and `reg_wdata[6]` into the result select on the next clock edge, but only when `conv_en`=0 or `spec_acc`=1. In any other case the write is ignored. Bits 5 and 3 can never be changed by a write.
- R4: With `cmd_dbl`=1 and `conv_en`=1, the command select inverts on a clock edge where `seq_busy`=0, `load_ok`=1, `restart`=1 and the block is not halted.
- R5: With `cmd_dbl`=0 the command select becomes 0 at the next edge, and with `res_dbl`=0 the result select becomes 0. This forcing overrides writes and events.
- R6: With `res_dbl`=1 and `conv_en`=1, the first `first_res_stored` pulse after reset, soft reset or disable only arms the block. Each later pulse inverts the result select while the block is not halted.
- R7: With `res_dbl`=1, `conv_en`=1 and the block not halted, `seq_abort`=1 inverts the result select. It also does so before the block is armed. An abort and a store in the same cycle invert the select once.
- R8: `ecc_dbl_err`=1 while `conv_en`=1 sets the fatal flag at the next edge. The flag stays set, `halt` follows it, and while it is set no event inverts either select.
- R9: The fatal flag clears at the edge after `conv_en` is sampled low. While `conv_en` is low, `ecc_dbl_err` is ignored.
- R10: `soft_rst`=1 clears both selects, the fatal flag and the armed state at the next edge, with priority over every other input.
- R11: The ready flag equals `seq_idle` while the block is not halted and reads 0 while it is halted.
- R12: If a permitted write and a toggle event fall in the same cycle, the written value is taken and the event is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Synchronous sequencer soft reset |
| conv_en | input | 1 | Converter enable |
| spec_acc | input | 1 | Special-mode access grant |
| cmd_dbl | input | 1 | Command lists double-buffered (1) or single (0) |
| res_dbl | input | 1 | Result lists double-buffered (1) or single (0) |
| load_ok | input | 1 | New command list loaded and valid |
| restart | input | 1 | Restart request strobe |
| seq_busy | input | 1 | Conversion or sequence in progress |
| first_res_stored | input | 1 | First result of current command list stored |
| seq_abort | input | 1 | Command list aborted |
| ecc_dbl_err | input | 1 | Double-bit ECC error seen |
| seq_idle | input | 1 | Sequencer idle with no pending abort |
| reg_wr | input | 1 | Status register write strobe |
| reg_wdata | input | 8 | Status register write data |
| reg_rdata | output | 8 | Status register read data |
| cmd_sel | output | 1 | Active command list |
| res_sel | output | 1 | Active result list |
| halt | output | 1 | Sequencer halt due to fatal error |

## Verification
Random cycles mix writes under every combination of enable and access grant with toggle events. This separates the write-protection path from the double-buffer toggles, and it shows which one wins when both fall in the same cycle. Rare ECC errors and soft resets, under both buffer modes, show whether halting freezes both selects and whether a disable or soft reset recovers the block. Directed sequences cover the unarmed first store against later stores, an abort before arming, restarts blocked by a busy sequencer, and flag bits written from software.

// File: rtl/lsel_pkg.sv
package lsel_pkg;
   localparam int STAT_W   = 8;
   localparam int POS_CMD  = 7;
   localparam int POS_RES  = 6;

   typedef struct packed {
      logic       cmd_sel;
      logic       res_sel;
      logic       fatal;
      logic       rsvd;
      logic       rdy;
      logic [2:0] zero;
   } stat_t;
endpackage

// File: rtl/lsel_sel_bit.sv
// One list-select flop: soft reset, single-buffer force, write, toggle.
module lsel_sel_bit #(
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic soft_rst,
   input  logic dbl,
   input  logic wr_ok,
   input  logic wr_val,
   input  logic toggle,
   output logic sel
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sel <= RST_VAL;
      else if (soft_rst) sel <= 1'b0;
      else if (!dbl)     sel <= 1'b0;
      else if (wr_ok)    sel <= wr_val;
      else if (toggle)   sel <= ~sel;
   end
endmodule

// File: rtl/lsel_err_latch.sv
// Sticky fatal flag for uncorrectable ECC errors.
module lsel_err_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic soft_rst,
   input  logic conv_en,
   input  logic ecc_dbl_err,
   output logic fatal
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     fatal <= 1'b0;
      else if (soft_rst || !conv_en)  fatal <= 1'b0;
      else if (ecc_dbl_err)           fatal <= 1'b1;
   end
endmodule

// File: rtl/lsel_res_track.sv
// Arming flag for the result list and its toggle event.
module lsel_res_track (
   input  logic clk,
   input  logic rst_n,
   input  logic soft_rst,
   input  logic conv_en,
   input  logic halt,
   input  logic dbl,
   input  logic first_res_stored,
   input  logic seq_abort,
   output logic toggle
);
   logic armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               armed_q <= 1'b0;
      else if (soft_rst || !conv_en)            armed_q <= 1'b0;
      else if (first_res_stored && !halt)       armed_q <= 1'b1;
   end

   assign toggle = conv_en && !halt && dbl &&
                   ((first_res_stored && armed_q) || seq_abort);
endmodule

// File: rtl/lsel_ready.sv
// Ready flag: combinational or registered variant.
module lsel_ready #(
   parameter bit READY_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic seq_idle,
   input  logic halt,
   output logic rdy
);
   logic rdy_d;
   assign rdy_d = seq_idle && !halt;

   generate
      if (READY_REG) begin : g_reg
         logic rdy_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rdy_q <= 1'b1;
            else        rdy_q <= rdy_d;
         end
         assign rdy = rdy_q;
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign rdy = rdy_d;
      end
   endgenerate
endmodule

// File: rtl/lsel_status_ctrl.sv
module lsel_status_ctrl
   import lsel_pkg::*;
#(
   parameter bit READY_REG = 1'b0,
   parameter int REG_W     = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst,
   input  logic             conv_en,
   input  logic             spec_acc,
   input  logic             cmd_dbl,
   input  logic             res_dbl,
   input  logic             load_ok,
   input  logic             restart,
   input  logic             seq_busy,
   input  logic             first_res_stored,
   input  logic             seq_abort,
   input  logic             ecc_dbl_err,
   input  logic             seq_idle,
   input  logic             reg_wr,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   output logic             cmd_sel,
   output logic             res_sel,
   output logic             halt
);
   generate
      if (REG_W != STAT_W) begin : g_bad_width
         $error("lsel_status_ctrl: REG_W must equal STAT_W");
      end
   endgenerate

   logic  fatal, wr_ok, cmd_tgl, res_tgl, rdy;
   stat_t stat;
   logic  unused_wd;

   assign unused_wd = ^reg_wdata[POS_RES-1:0];
   assign wr_ok     = reg_wr && (!conv_en || spec_acc);
   assign halt      = fatal;
   assign cmd_tgl   = conv_en && !fatal && cmd_dbl && !seq_busy &&
                      load_ok && restart;

   lsel_err_latch u_err (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .conv_en(conv_en), .ecc_dbl_err(ecc_dbl_err), .fatal(fatal));

   lsel_res_track u_rtrk (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .conv_en(conv_en),
      .halt(fatal), .dbl(res_dbl), .first_res_stored(first_res_stored),
      .seq_abort(seq_abort), .toggle(res_tgl));

   lsel_sel_bit u_cmd (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .dbl(cmd_dbl),
      .wr_ok(wr_ok), .wr_val(reg_wdata[POS_CMD]), .toggle(cmd_tgl),
      .sel(cmd_sel));

   lsel_sel_bit u_res (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .dbl(res_dbl),
      .wr_ok(wr_ok), .wr_val(reg_wdata[POS_RES]), .toggle(res_tgl),
      .sel(res_sel));

   lsel_ready #(.READY_REG(READY_REG)) u_rdy (
      .clk(clk), .rst_n(rst_n), .seq_idle(seq_idle), .halt(fatal),
      .rdy(rdy));

   always_comb begin
      stat         = '0;
      stat.cmd_sel = cmd_sel;
      stat.res_sel = res_sel;
      stat.fatal   = fatal;
      stat.rdy     = rdy;
   end

   assign reg_rdata = stat;
endmodule

// File: rtl/lsel_status_chk.sv
module lsel_status_chk #(
   parameter bit READY_REG = 1'b0
) (
   input logic       clk,
   input logic       rst_n,
   input logic       soft_rst,
   input logic       conv_en,
   input logic       spec_acc,
   input logic       cmd_dbl,
   input logic       res_dbl,
   input logic       load_ok,
   input logic       restart,
   input logic       seq_busy,
   input logic       seq_abort,
   input logic       ecc_dbl_err,
   input logic       reg_wr,
   input logic [7:0] wd,
   input logic [7:0] stat,
   input logic       halt
);
   assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      stat[4] == 1'b0 && stat[2:0] == 3'b000);

   assert_write_R3_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && (!conv_en || spec_acc) && cmd_dbl && res_dbl && !soft_rst)
      |=> (stat[7:6] == $past(wd[7:6])));

   assert_cmd_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_dbl && conv_en && !halt && !seq_busy && load_ok && restart &&
       !soft_rst && !(reg_wr && spec_acc)) |=> (stat[7] != $past(stat[7])));

   assert_cmd_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_dbl |=> !stat[7]);

   assert_res_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !res_dbl |=> !stat[6]);

   assert_abort_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (res_dbl && conv_en && !halt && seq_abort && !soft_rst &&
       !(reg_wr && spec_acc)) |=> (stat[6] != $past(stat[6])));

   assert_ecc_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ecc_dbl_err && conv_en && !soft_rst) |=> (stat[5] && halt));

   assert_halt_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (halt && conv_en && cmd_dbl && res_dbl && !soft_rst && !reg_wr)
      |=> $stable(stat[7:6]));

   assert_disable_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !conv_en |=> !stat[5]);

   assert_soft_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (stat[7:5] == 3'b000));

   generate
      if (!READY_REG) begin : g_rdy_chk
         assert_ready_halt_R11: assert property (@(posedge clk) disable iff (!rst_n)
            halt |-> !stat[3]);
      end
   endgenerate
endmodule

bind lsel_status_ctrl lsel_status_chk #(.READY_REG(READY_REG)) u_chk (
   .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .conv_en(conv_en),
   .spec_acc(spec_acc), .cmd_dbl(cmd_dbl), .res_dbl(res_dbl),
   .load_ok(load_ok), .restart(restart), .seq_busy(seq_busy),
   .seq_abort(seq_abort), .ecc_dbl_err(ecc_dbl_err), .reg_wr(reg_wr),
   .wd(reg_wdata[7:0]), .stat(reg_rdata[7:0]), .halt(halt));

// File: tb/sim_lsel_status_ctrl.sv
`timescale 1ns/1ps
module sim_lsel_status_ctrl;
   logic clk = 1'b0;
   logic rst_n, soft_rst, conv_en, spec_acc, cmd_dbl, res_dbl, load_ok;
   logic restart, seq_busy, first_res_stored, seq_abort, ecc_dbl_err;
   logic seq_idle, reg_wr;
   logic [7:0] reg_wdata, reg_rdata;
   logic cmd_sel, res_sel, halt;

   int checks = 0, errors = 0;
   bit done = 0;
   bit m_cmd = 0, m_res = 0, m_err = 0, m_arm = 0;

   always #2 clk = ~clk;

   lsel_status_ctrl u0 (.*);

   function automatic logic [7:0] exp_stat();
      return {m_cmd, m_res, m_err, 1'b0, seq_idle && !m_err, 3'b000};
   endfunction

   task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
      end
   endtask

   task automatic idle_inputs();
      soft_rst = 0; conv_en = 1; spec_acc = 0; cmd_dbl = 1; res_dbl = 1;
      load_ok = 0; restart = 0; seq_busy = 0; first_res_stored = 0;
      seq_abort = 0; ecc_dbl_err = 0; seq_idle = 1; reg_wr = 0; reg_wdata = 0;
   endtask

   // Check outputs against the model, then advance model and clock.
   task automatic tick(string tag);
      bit wr_ok, tc, tr, n_cmd, n_res, n_err, n_arm;
      #1;
      chk(tag, "rdata", reg_rdata, exp_stat());
      chk(tag, "sel/halt", {5'b0, cmd_sel, res_sel, halt}, {5'b0, m_cmd, m_res, m_err});
      wr_ok = reg_wr && (!conv_en || spec_acc);
      tc = conv_en && !m_err && cmd_dbl && !seq_busy && load_ok && restart;
      tr = conv_en && !m_err && res_dbl && ((first_res_stored && m_arm) || seq_abort);
      if (!rst_n || soft_rst) begin
         n_cmd = 0; n_res = 0; n_err = 0; n_arm = 0;
      end else begin
         n_err = conv_en ? (m_err || ecc_dbl_err) : 1'b0;
         n_arm = conv_en ? (m_arm || (first_res_stored && !m_err)) : 1'b0;
         n_cmd = !cmd_dbl ? 1'b0 : wr_ok ? reg_wdata[7] : tc ? ~m_cmd : m_cmd;
         n_res = !res_dbl ? 1'b0 : wr_ok ? reg_wdata[6] : tr ? ~m_res : m_res;
      end
      m_cmd = n_cmd; m_res = n_res; m_err = n_err; m_arm = n_arm;
      @(negedge clk);
      idle_inputs();
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      idle_inputs();
      rst_n = 0;
      @(negedge clk);
      // R2: reset value 0x08 with idle sequencer
      tick("R2"); tick("R2");
      rst_n = 1;
      tick("R2");

      // R3: write ignored while enabled without access grant
      reg_wr = 1; reg_wdata = 8'hC0; tick("R3"); tick("R3");
      // R3: write accepted while disabled; flag bits not writable
      conv_en = 0; reg_wr = 1; reg_wdata = 8'hE8; tick("R3"); tick("R3");
      // R5: single-buffer forces zero over a write
      conv_en = 0; cmd_dbl = 0; reg_wr = 1; reg_wdata = 8'hC0; tick("R5");
      res_dbl = 0; tick("R5"); tick("R5");
      // R4: toggle on restart with load-OK, blocked while busy
      load_ok = 1; restart = 1; tick("R4"); tick("R4");
      load_ok = 1; restart = 1; seq_busy = 1; tick("R4"); tick("R4");
      // R6: first store arms only, second toggles
      conv_en = 0; tick("R6");
      first_res_stored = 1; tick("R6"); tick("R6");
      first_res_stored = 1; tick("R6"); tick("R6");
      // R7: abort toggles, also before arming
      conv_en = 0; tick("R7");
      seq_abort = 1; tick("R7"); tick("R7");
      seq_abort = 1; first_res_stored = 1; tick("R7"); tick("R7");
      // R12: permitted write beats toggle event
      spec_acc = 1; reg_wr = 1; reg_wdata = 8'h00; load_ok = 1; restart = 1;
      seq_abort = 1; tick("R12"); tick("R12");
      // R8: ECC error halts, blocks toggles, ready drops (R11)
      ecc_dbl_err = 1; tick("R8"); tick("R8");
      load_ok = 1; restart = 1; seq_abort = 1; tick("R8"); tick("R11");
      // R9: disable clears error; ECC ignored while disabled
      conv_en = 0; tick("R9"); conv_en = 0; ecc_dbl_err = 1; tick("R9"); tick("R9");
      // R10: soft reset clears error and selects
      spec_acc = 1; reg_wr = 1; reg_wdata = 8'hC0; tick("R10");
      ecc_dbl_err = 1; tick("R10");
      soft_rst = 1; ecc_dbl_err = 1; load_ok = 1; restart = 1; tick("R10"); tick("R10");
      // R11: ready follows idle
      seq_idle = 0; tick("R11"); tick("R11");

      // Random mix (R1, R4, R6, R7, R8, R12 all exercised by the model)
      for (int i = 0; i < 4000; i++) begin
         soft_rst         = ($urandom % 48) == 0;
         conv_en          = ($urandom % 10) != 0;
         spec_acc         = ($urandom % 4) == 0;
         cmd_dbl          = ($urandom % 12) != 0;
         res_dbl          = ($urandom % 12) != 0;
         load_ok          = ($urandom % 2) == 0;
         restart          = ($urandom % 3) == 0;
         seq_busy         = ($urandom % 3) == 0;
         first_res_stored = ($urandom % 4) == 0;
         seq_abort        = ($urandom % 10) == 0;
         ecc_dbl_err      = ($urandom % 80) == 0;
         seq_idle         = ($urandom % 2) == 0;
         reg_wr           = ($urandom % 6) == 0;
         reg_wdata        = 8'($urandom);
         tick("R1");
      end
      tick("R1");

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule